// File: doc/BRIEF.md
# H-Bridge Gate Encoder with Dead-Time Sequencing

This block turns a requested drive mode for one motor winding into the four gate enables of a full bridge: the high-side and low-side switches of the left leg and of the right leg. The mode is one of off, charge, slow decay or fast decay, and a direction bit gives the sign of the winding current. A chopper controller upstream changes the mode every few microseconds. The encoder makes sure that no leg ever conducts from supply to ground.

Any change of the requested mode or direction is not applied at once. The block first turns off all four switches for a fixed number of clock cycles. Only when that gap has fully elapsed does it switch on the new pattern. If the request changes again during the gap, the new request takes the place of the pending one and the gap starts over. A disable input and a thermal-fault input both force every switch off without stopping the sequencer. The fault also asserts a pull-down enable for an external open-drain flag line. All outputs are registered and therefore follow the inputs by one clock.

Top module: `hbridge_gate_enc`

## Requirements
- R1: While rst_ni is low, and in the first cycles after reset with mode off requested, all four gate outputs and fault_pull_o are 0, and the applied mode is off.
- R2: With dir_i = 0 and the mode code applied (0 off, 1 charge, 2 slow decay, 3 fast decay), the gates {hi_left, hi_right, lo_left, lo_right} are 0000 for off, 1001 for charge, 0011 for slow decay and 0110 for fast decay.
- R3: With dir_i = 1, the gates are 0000 for off, 0110 for charge, 0011 for slow decay and 1001 for fast decay.
- R4: When the request {mode_i, dir_i} first differs from the applied one, all gates are 0 for exactly DEAD_CYC cycles, starting one clock after the change. The new pattern appears in the cycle after that.
- R5: A request that changes while a gap is running replaces the pending request and restarts the gap at its full length of DEAD_CYC cycles.
- R6: One clock after disable_i is sampled high, all gates are 0 while the sequencer keeps running. One clock after it is released, the applied pattern returns with no new gap.
- R7: One clock after therm_fault_i is sampled high, all gates are 0 and fault_pull_o is 1. One clock after the fault clears, fault_pull_o is 0.
- R8: hi_left and lo_left are never 1 in the same cycle, and neither are hi_right and lo_right.
- R9: The gate outputs never change directly from one non-zero pattern to a different non-zero pattern.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | Requested drive mode: 0 off, 1 charge, 2 slow decay, 3 fast decay |
| dir_i | input | 1 | Current direction: 0 positive, 1 negative |
| disable_i | input | 1 | Forces all switches off while high |
| therm_fault_i | input | 1 | Thermal fault: forces all switches off and asserts the flag |
| hi_left_o | output | 1 | Left high-side gate enable |
| hi_right_o | output | 1 | Right high-side gate enable |
| lo_left_o | output | 1 | Left low-side gate enable |
| lo_right_o | output | 1 | Right low-side gate enable |
| fault_pull_o | output | 1 | 1 pulls the open-drain fault line low; 0 releases it |

## Verification
The in-line assertions check on every cycle that:
- neither leg conducts straight through;
- no non-zero pattern is replaced directly by another non-zero pattern;
- the disable and fault overrides take effect one clock after they are sampled;
- a request change during a gap reloads the counter;
- the applied mode stays stable while the gap counts down.

Only the bench scenarios can show the rest:
- the exact length of each gap;
- the restart of a gap when the request changes late in it;
- the pattern for every mode and direction;
- the return of the pattern after the disable input is released.

// File: rtl/hbg_pkg.sv
package hbg_pkg;
  typedef enum logic [1:0] {
    DRV_OFF    = 2'd0,
    DRV_CHARGE = 2'd1,
    DRV_SLOW   = 2'd2,
    DRV_FAST   = 2'd3
  } drv_mode_e;

  typedef struct packed {
    drv_mode_e mode;
    logic      neg;
  } drv_req_t;

  typedef struct packed {
    logic hl;
    logic hr;
    logic ll;
    logic lr;
  } gate_t;
endpackage

// File: rtl/hbg_switch_map.sv
module hbg_switch_map
  import hbg_pkg::*;
(
  input  drv_req_t req_i,
  output gate_t    gate_o
);
  always_comb begin
    gate_o = '0;
    unique case (req_i.mode)
      DRV_OFF:    gate_o = '0;
      DRV_CHARGE: gate_o = req_i.neg ? 4'b0110 : 4'b1001;
      DRV_SLOW:   gate_o = 4'b0011;
      DRV_FAST:   gate_o = req_i.neg ? 4'b1001 : 4'b0110;
      default:    gate_o = '0;
    endcase
  end
endmodule

// File: rtl/hbg_dead_timer.sv
module hbg_dead_timer
  import hbg_pkg::*;
#(
  parameter int unsigned DEAD_CYC = 15
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  drv_req_t req_i,
  output drv_req_t applied_nxt_o,
  output logic     gap_nxt_o
);
  localparam int unsigned CNT_W = (DEAD_CYC > 1) ? $clog2(DEAD_CYC) : 1;
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(DEAD_CYC - 1);

  drv_req_t cur_q, cur_d, pend_q, pend_d;
  logic busy_q, busy_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cur_d  = cur_q;
    pend_d = pend_q;
    busy_d = busy_q;
    cnt_d  = cnt_q;
    if (!busy_q) begin
      if (req_i != cur_q) begin
        busy_d = 1'b1;
        pend_d = req_i;
        cnt_d  = LOAD;
      end
    end else if (req_i != pend_q) begin
      // late change: replace target, full gap again
      pend_d = req_i;
      cnt_d  = LOAD;
    end else if (cnt_q == '0) begin
      cur_d  = pend_q;
      busy_d = 1'b0;
    end else begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_q  <= drv_req_t'('0);
      pend_q <= drv_req_t'('0);
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      cur_q  <= cur_d;
      pend_q <= pend_d;
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
    end
  end

  assign applied_nxt_o = cur_d;
  assign gap_nxt_o     = busy_d;

  // R5
  gap_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && req_i != pend_q) |=> (busy_q && cnt_q == LOAD));

  // R4
  gap_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && cnt_q != '0 && req_i == pend_q) |=> (busy_q && cur_q == $past(cur_q)));
endmodule

// File: rtl/hbridge_gate_enc.sv
module hbridge_gate_enc
  import hbg_pkg::*;
#(
  parameter int unsigned DEAD_CYC = 15
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] mode_i,
  input  logic       dir_i,
  input  logic       disable_i,
  input  logic       therm_fault_i,
  output logic       hi_left_o,
  output logic       hi_right_o,
  output logic       lo_left_o,
  output logic       lo_right_o,
  output logic       fault_pull_o
);
  drv_req_t req, applied_nxt;
  logic     gap_nxt;
  gate_t    map_gate, gate_d, gate_q;
  logic     flag_q;

  assign req.mode = drv_mode_e'(mode_i);
  assign req.neg  = dir_i;

  hbg_dead_timer #(.DEAD_CYC(DEAD_CYC)) i_timer (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .req_i         (req),
    .applied_nxt_o (applied_nxt),
    .gap_nxt_o     (gap_nxt)
  );

  hbg_switch_map i_map (
    .req_i  (applied_nxt),
    .gate_o (map_gate)
  );

  assign gate_d = (gap_nxt || disable_i || therm_fault_i) ? gate_t'('0) : map_gate;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gate_q <= '0;
      flag_q <= 1'b0;
    end else begin
      gate_q <= gate_d;
      flag_q <= therm_fault_i;
    end
  end

  assign hi_left_o    = gate_q.hl;
  assign hi_right_o   = gate_q.hr;
  assign lo_left_o    = gate_q.ll;
  assign lo_right_o   = gate_q.lr;
  assign fault_pull_o = flag_q;

  // R8
  no_shoot_left_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(hi_left_o && lo_left_o));

  // R8
  no_shoot_right_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(hi_right_o && lo_right_o));

  // R9
  no_direct_swap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gate_q != '0 && $past(gate_q) != '0) |-> (gate_q == $past(gate_q)));

  // R6
  disable_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $past(disable_i)) |-> (gate_q == '0));

  // R7
  fault_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $past(therm_fault_i)) |-> (gate_q == '0 && fault_pull_o));
endmodule

// File: tb/test_hbridge_gate_enc.sv
`timescale 1ns/1ps
module test_hbridge_gate_enc;
  localparam int unsigned DEAD = 15;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [1:0] mode = 2'd0;
  logic dir = 1'b0, dis = 1'b0, flt = 1'b0;
  logic hl, hr, ll, lr, fpull;

  always #2.5 clk = ~clk;

  hbridge_gate_enc #(.DEAD_CYC(DEAD)) i_hbridge_gate_enc (
    .clk_i(clk), .rst_ni(rst_ni), .mode_i(mode), .dir_i(dir),
    .disable_i(dis), .therm_fault_i(flt),
    .hi_left_o(hl), .hi_right_o(hr), .lo_left_o(ll), .lo_right_o(lr),
    .fault_pull_o(fpull)
  );

  typedef struct { logic [4:0] bits; string tag; } item_t;
  item_t sb[$];
  int checks = 0, fails = 0;
  bit done = 0;

  // requirement-level reference state
  logic [2:0] m_cur, m_pend;
  bit m_busy;
  int m_left;

  function automatic logic [3:0] pattern(logic [2:0] r);
    case (r[2:1])
      2'd1: return r[0] ? 4'b0110 : 4'b1001;
      2'd2: return 4'b0011;
      2'd3: return r[0] ? 4'b1001 : 4'b0110;
      default: return 4'b0000;
    endcase
  endfunction

  task automatic drive(input logic [1:0] m, input logic d, input logic ds,
                       input logic f, input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      logic [2:0] r;
      item_t it;
      @(negedge clk);
      mode = m; dir = d; dis = ds; flt = f;
      r = {m, d};
      if (!m_busy) begin
        if (r != m_cur) begin m_busy = 1; m_pend = r; m_left = DEAD - 1; end
      end else if (r != m_pend) begin
        m_pend = r; m_left = DEAD - 1;
      end else if (m_left == 0) begin
        m_cur = m_pend; m_busy = 0;
      end else m_left--;
      it.bits = {(m_busy || ds || f) ? 4'b0000 : pattern(m_cur), f};
      it.tag = tag;
      sb.push_back(it);
    end
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk); #1;
      if (sb.size() > 0) begin
        item_t e;
        logic [4:0] got;
        e = sb.pop_front();
        got = {hl, hr, ll, lr, fpull};
        checks++;
        if (got !== e.bits) begin
          fails++;
          $display("FAIL %s: got %b expected %b at %0t", e.tag, got, e.bits, $time);
        end
        checks++;
        if ((hl && ll) || (hr && lr)) begin
          fails++;
          $display("FAIL R8: got %b expected no leg shoot-through", got[4:1]);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    m_cur = 3'b000; m_pend = 3'b000; m_busy = 0; m_left = 0;
    repeat (3) @(negedge clk);
    checks++;
    if ({hl, hr, ll, lr, fpull} !== 5'b0) begin
      fails++;
      $display("FAIL R1: got %b expected 00000", {hl, hr, ll, lr, fpull});
    end
    rst_ni = 1'b1;
    drive(2'd0, 0, 0, 0, 4, "R1");
    // positive direction, each mode through a full gap
    drive(2'd1, 0, 0, 0, DEAD + 6, "R2/R4 charge+");
    drive(2'd2, 0, 0, 0, DEAD + 6, "R2/R4 slow+");
    drive(2'd3, 0, 0, 0, DEAD + 6, "R2/R4 fast+");
    drive(2'd1, 0, 0, 0, DEAD + 6, "R9 fast->charge+");
    drive(2'd0, 0, 0, 0, DEAD + 4, "R2 off");
    // negative direction
    drive(2'd1, 1, 0, 0, DEAD + 6, "R3 charge-");
    drive(2'd2, 1, 0, 0, DEAD + 6, "R3 slow-");
    drive(2'd2, 0, 0, 0, DEAD + 6, "R4 dir flip in slow");
    drive(2'd3, 1, 0, 0, DEAD + 6, "R3 fast-");
    // late request during gap
    drive(2'd1, 0, 0, 0, 6, "R5 first request");
    drive(2'd3, 0, 0, 0, DEAD + 6, "R5 replaced request");
    drive(2'd2, 0, 0, 0, DEAD - 1, "R5 near expiry");
    drive(2'd1, 1, 0, 0, DEAD + 6, "R5 restart at last cycle");
    // disable
    drive(2'd1, 1, 1, 0, 6, "R6 disabled");
    drive(2'd1, 1, 0, 0, 4, "R6 released no gap");
    drive(2'd2, 1, 1, 0, DEAD + 4, "R6 gap runs while disabled");
    drive(2'd2, 1, 0, 0, 4, "R6 new pattern after release");
    // thermal fault
    drive(2'd2, 1, 0, 1, 6, "R7 fault");
    drive(2'd2, 1, 0, 0, 4, "R7 fault cleared");
    drive(2'd3, 0, 0, 1, DEAD + 4, "R7 fault during gap");
    drive(2'd3, 0, 0, 0, 4, "R7 released");
    drive(2'd0, 0, 0, 0, DEAD + 4, "R2 back to off");
    wait (sb.size() == 0);
    @(posedge clk); #2;
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule